// File: doc/BRIEF.md
# Barrel Shifter Operand Unit

This block forms the second operand of a 32-bit datapath ALU together with the shifter carry-out that the flag logic may later commit. It accepts one of three operand encodings:

- an 8-bit constant rotated right by an even amount;
- a register value shifted by a 5-bit constant;
- a register value shifted by an amount held in a second register.

The shift type picks a logical left, logical right, arithmetic right or rotate right. Special amounts are reinterpreted so that the whole shifter range is reachable from short encodings.

The result is registered. Operand and carry-out appear one clock after the inputs are presented, which lets the block sit as a pipeline stage between register read and execute. Instruction decode, the ALU itself and flag writeback live elsewhere.

Top module: `bsh_operand_unit`

## Requirements
- R1: With form 0 (constant), the zero-extended 8-bit constant is rotated right by twice the 4-bit rotate field. A rotate field of 0 passes the constant with carry-out equal to carry_i. Otherwise carry-out equals bit 31 of the result.
- R2: Shift type codes are 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. A nonzero shift by n below 32 gives the shifted value, and the carry-out is the last bit shifted out: bit 32-n for left shifts, bit n-1 for right shifts and rotates.
- R3: With form 1 (constant amount), logical left by 0 passes the register value and carry_i unchanged.
- R4: With form 1, logical right by 0 and arithmetic right by 0 both act as a shift by 32. The result is 0 for the logical shift and 32 copies of bit 31 for the arithmetic shift, with carry-out equal to the old bit 31 in both cases.
- R5: With form 1, rotate right by 0 is a one-bit rotate through carry: carry_i enters bit 31, bits 31..1 move down one place, and the old bit 0 becomes the carry-out.
- R6: With form 2 (register amount), only bits 7..0 of the amount register count. The logical shifts limit the amount to 33 and the arithmetic shift limits it to 32. A logical shift by 32 gives 0 with carry-out equal to bit 0 (left) or bit 31 (right). A logical shift by 33 or more gives 0 with carry-out 0. An arithmetic shift by 32 or more fills with bit 31, and the carry-out is bit 31.
- R7: With form 2, an amount of 0 leaves the value and carry_i untouched for every shift type.
- R8: With form 2 and rotate right, a nonzero amount whose bits 4..0 are zero rotates by 32: the value is unchanged and the carry-out is bit 31.
- R9: With form 2, a source whose register index is 15 has 4 added to its value, for both the shifted value and the amount register. The addition happens before the amount is cut to 8 bits. With form 1 no such adjustment is made.
- R10: Form code 3 behaves exactly like form 1.
- R11: operand_o and carry_o change only on the rising clock edge after the inputs are applied. While rst_n is low both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| form_i | input | 2 | Operand form: 0 constant, 1 constant amount, 2 register amount, 3 as 1 |
| shtype_i | input | 2 | Shift type: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| imm_i | input | 8 | Constant for form 0 |
| rot_i | input | 4 | Rotate field for form 0 (rotates by twice this value) |
| shamt_i | input | 5 | Constant shift amount for forms 1 and 3 |
| val_reg_i | input | 32 | Register value to be shifted |
| val_idx_i | input | 4 | Register index of val_reg_i |
| amt_reg_i | input | 32 | Register holding the shift amount for form 2 |
| amt_idx_i | input | 4 | Register index of amt_reg_i |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Registered shifter result |
| carry_o | output | 1 | Registered shifter carry-out |

## Verification
Every result of this block is due on the first rising edge after its inputs are driven. The operand and the carry-out both come from the same single register stage, so no output has a longer path than the other.

The driver changes inputs on the falling edge and queues the expected pair. The monitor pops one entry per rising edge and compares it 1 ns after that edge, so every comparison falls in exactly the cycle where the stage has just loaded.

Expected values come from a bit-at-a-time model that steps the shift one position per iteration. It shares no arithmetic with the wide shifts used in the design.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  typedef enum logic [1:0] {
    FORM_CONST     = 2'd0,
    FORM_CONST_AMT = 2'd1,
    FORM_REG_AMT   = 2'd2,
    FORM_CONST_ALT = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shtype_e;

  typedef enum logic [2:0] {
    K_KEEP = 3'd0,
    K_LSL  = 3'd1,
    K_LSR  = 3'd2,
    K_ASR  = 3'd3,
    K_ROR  = 3'd4,
    K_RRX  = 3'd5
  } kind_e;

  localparam int CMD_AMT_W = 7;

  typedef struct packed {
    kind_e                  kind;
    logic [CMD_AMT_W-1:0]   amt;
  } shift_cmd_t;

endpackage

// File: rtl/bsh_cmd_decode.sv
module bsh_cmd_decode
  import bsh_pkg::*;
#(
  parameter int DW       = 32,
  parameter int IMM_W    = 8,
  parameter int ROT_W    = 4,
  parameter int SHAMT_W  = 5,
  parameter int REGAMT_W = 8,
  parameter int IDX_W    = 4,
  parameter int PC_IDX   = 15,
  parameter int PC_ADJ   = 4
) (
  input  logic [1:0]          form,
  input  logic [1:0]          shtype,
  input  logic [IMM_W-1:0]    imm,
  input  logic [ROT_W-1:0]    rot,
  input  logic [SHAMT_W-1:0]  shamt,
  input  logic [DW-1:0]       val_reg,
  input  logic [IDX_W-1:0]    val_idx,
  input  logic [DW-1:0]       amt_reg,
  input  logic [IDX_W-1:0]    amt_idx,
  output logic [DW-1:0]       value,
  output shift_cmd_t          cmd
);

  localparam int LOG_CAP = DW + 1;
  localparam int ARI_CAP = DW;
  localparam int ROT5_W  = $clog2(DW);

  logic [DW-1:0]       val_adj;
  logic [DW-1:0]       amt_adj;
  logic [REGAMT_W-1:0] amt_lo;
  logic [ROT5_W-1:0]   amt_rot;

  always_comb begin
    val_adj = val_reg + ((val_idx == IDX_W'(PC_IDX)) ? DW'(PC_ADJ) : '0);
    amt_adj = amt_reg + ((amt_idx == IDX_W'(PC_IDX)) ? DW'(PC_ADJ) : '0);
    amt_lo  = amt_adj[REGAMT_W-1:0];
    amt_rot = amt_lo[ROT5_W-1:0];
  end

  always_comb begin
    value = val_reg;
    cmd   = '{kind: K_KEEP, amt: '0};
    unique case (form_e'(form))
      FORM_CONST: begin
        value = DW'(imm);
        cmd   = '{kind: K_ROR, amt: CMD_AMT_W'({rot, 1'b0})};
      end
      FORM_REG_AMT: begin
        value = val_adj;
        unique case (shtype_e'(shtype))
          SH_LSL: cmd = '{kind: K_LSL,
                          amt: (amt_lo > REGAMT_W'(LOG_CAP)) ? CMD_AMT_W'(LOG_CAP)
                                                              : CMD_AMT_W'(amt_lo)};
          SH_LSR: cmd = '{kind: K_LSR,
                          amt: (amt_lo > REGAMT_W'(LOG_CAP)) ? CMD_AMT_W'(LOG_CAP)
                                                              : CMD_AMT_W'(amt_lo)};
          SH_ASR: cmd = '{kind: K_ASR,
                          amt: (amt_lo > REGAMT_W'(ARI_CAP)) ? CMD_AMT_W'(ARI_CAP)
                                                              : CMD_AMT_W'(amt_lo)};
          default: begin
            if (amt_lo == '0)
              cmd = '{kind: K_KEEP, amt: '0};
            else if (amt_rot == '0)
              cmd = '{kind: K_ROR, amt: CMD_AMT_W'(DW)};
            else
              cmd = '{kind: K_ROR, amt: CMD_AMT_W'(amt_rot)};
          end
        endcase
      end
      default: begin
        value = val_reg;
        unique case (shtype_e'(shtype))
          SH_LSL: cmd = '{kind: K_LSL, amt: CMD_AMT_W'(shamt)};
          SH_LSR: cmd = '{kind: K_LSR,
                          amt: (shamt == '0) ? CMD_AMT_W'(DW) : CMD_AMT_W'(shamt)};
          SH_ASR: cmd = '{kind: K_ASR,
                          amt: (shamt == '0) ? CMD_AMT_W'(DW) : CMD_AMT_W'(shamt)};
          default: cmd = (shamt == '0) ? '{kind: K_RRX, amt: CMD_AMT_W'(1)}
                                       : '{kind: K_ROR, amt: CMD_AMT_W'(shamt)};
        endcase
      end
    endcase
  end

endmodule

// File: rtl/bsh_shift_core.sv
module bsh_shift_core
  import bsh_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] value,
  input  shift_cmd_t    cmd,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);

  localparam int WW = 2 * DW;

  logic [WW-1:0] lsl_w;
  logic [WW-1:0] lsr_w;
  logic [WW-1:0] asr_w;
  logic [WW-1:0] ror_w;

  always_comb begin
    lsl_w = {{DW{1'b0}}, value} << cmd.amt;
    lsr_w = {value, {DW{1'b0}}} >> cmd.amt;
    asr_w = WW'($signed({value, {DW{1'b0}}}) >>> cmd.amt);
    ror_w = {value, value} >> cmd.amt;
  end

  always_comb begin
    res  = value;
    cout = cin;
    if (cmd.amt != '0) begin
      unique case (cmd.kind)
        K_LSL: begin res = lsl_w[DW-1:0];  cout = lsl_w[DW];   end
        K_LSR: begin res = lsr_w[WW-1:DW]; cout = lsr_w[DW-1]; end
        K_ASR: begin res = asr_w[WW-1:DW]; cout = asr_w[DW-1]; end
        K_ROR: begin res = ror_w[DW-1:0];  cout = ror_w[DW-1]; end
        K_RRX: begin res = {cin, value[DW-1:1]}; cout = value[0]; end
        default: begin res = value; cout = cin; end
      endcase
    end
  end

endmodule

// File: rtl/bsh_operand_unit.sv
module bsh_operand_unit
  import bsh_pkg::*;
#(
  parameter int DW       = 32,
  parameter int IMM_W    = 8,
  parameter int ROT_W    = 4,
  parameter int SHAMT_W  = 5,
  parameter int REGAMT_W = 8,
  parameter int IDX_W    = 4,
  parameter int PC_IDX   = 15,
  parameter int PC_ADJ   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          form_i,
  input  logic [1:0]          shtype_i,
  input  logic [IMM_W-1:0]    imm_i,
  input  logic [ROT_W-1:0]    rot_i,
  input  logic [SHAMT_W-1:0]  shamt_i,
  input  logic [DW-1:0]       val_reg_i,
  input  logic [IDX_W-1:0]    val_idx_i,
  input  logic [DW-1:0]       amt_reg_i,
  input  logic [IDX_W-1:0]    amt_idx_i,
  input  logic                carry_i,
  output logic [DW-1:0]       operand_o,
  output logic                carry_o
);

  logic [DW-1:0] dec_value;
  shift_cmd_t    dec_cmd;
  logic [DW-1:0] sh_res;
  logic          sh_cout;
  logic [DW-1:0] operand_q, operand_d;
  logic          carry_q, carry_d;

  bsh_cmd_decode #(
    .DW(DW), .IMM_W(IMM_W), .ROT_W(ROT_W), .SHAMT_W(SHAMT_W),
    .REGAMT_W(REGAMT_W), .IDX_W(IDX_W), .PC_IDX(PC_IDX), .PC_ADJ(PC_ADJ)
  ) i_decode (
    .form(form_i), .shtype(shtype_i), .imm(imm_i), .rot(rot_i),
    .shamt(shamt_i), .val_reg(val_reg_i), .val_idx(val_idx_i),
    .amt_reg(amt_reg_i), .amt_idx(amt_idx_i),
    .value(dec_value), .cmd(dec_cmd)
  );

  bsh_shift_core #(.DW(DW)) i_core (
    .value(dec_value), .cmd(dec_cmd), .cin(carry_i),
    .res(sh_res), .cout(sh_cout)
  );

  always_comb begin
    operand_d = sh_res;
    carry_d   = sh_cout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      operand_q <= '0;
      carry_q   <= 1'b0;
    end else begin
      operand_q <= operand_d;
      carry_q   <= carry_d;
    end
  end

  assign operand_o = operand_q;
  assign carry_o   = carry_q;

  // R1
  const_norot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (form_i == 2'd0 && rot_i == '0)
      |=> (operand_o == DW'($past(imm_i)) && carry_o == $past(carry_i)));

  // R3
  lsl_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (form_i == 2'd1 && shtype_i == 2'd0 && shamt_i == '0)
      |=> (operand_o == $past(val_reg_i) && carry_o == $past(carry_i)));

  // R4
  lsr_zero_is32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (form_i == 2'd1 && shtype_i == 2'd1 && shamt_i == '0)
      |=> (operand_o == '0 && carry_o == $past(val_reg_i[DW-1])));

  // R5
  rrx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (form_i == 2'd1 && shtype_i == 2'd3 && shamt_i == '0)
      |=> (operand_o[DW-1] == $past(carry_i) && carry_o == $past(val_reg_i[0])));

  // R7
  reg_zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (form_i == 2'd2 && amt_idx_i != IDX_W'(PC_IDX) && val_idx_i != IDX_W'(PC_IDX)
     && amt_reg_i[REGAMT_W-1:0] == '0)
      |=> (operand_o == $past(val_reg_i) && carry_o == $past(carry_i)));

endmodule

// File: tb/test_bsh_operand_unit.sv
`timescale 1ns/1ps
module test_bsh_operand_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  form_i, shtype_i;
  logic [7:0]  imm_i;
  logic [3:0]  rot_i;
  logic [4:0]  shamt_i;
  logic [31:0] val_reg_i, amt_reg_i;
  logic [3:0]  val_idx_i, amt_idx_i;
  logic        carry_i;
  logic [31:0] operand_o;
  logic        carry_o;

  always #2 clk = ~clk;

  bsh_operand_unit i_bsh_operand_unit (
    .clk(clk), .rst_n(rst_n), .form_i(form_i), .shtype_i(shtype_i),
    .imm_i(imm_i), .rot_i(rot_i), .shamt_i(shamt_i),
    .val_reg_i(val_reg_i), .val_idx_i(val_idx_i),
    .amt_reg_i(amt_reg_i), .amt_idx_i(amt_idx_i),
    .carry_i(carry_i), .operand_o(operand_o), .carry_o(carry_o)
  );

  typedef struct {
    logic [31:0] op;
    logic        c;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // bit-serial reference model
  function automatic logic [32:0] model(
    input logic [1:0] form, input logic [1:0] typ, input logic [7:0] imm,
    input logic [3:0] rot, input logic [4:0] shamt,
    input logic [31:0] vreg, input logic [3:0] vidx,
    input logic [31:0] areg, input logic [3:0] aidx, input logic cin);
    logic [31:0] v;
    logic        c;
    int          n;
    logic [31:0] a32;
    int          a;
    c = cin;
    if (form == 2'd0) begin
      v = {24'd0, imm};
      for (int i = 0; i < 2 * rot; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
      if (rot != 0) c = v[31];
      return {c, v};
    end
    if (form == 2'd2) begin
      v   = vreg + ((vidx == 4'd15) ? 32'd4 : 32'd0);
      a32 = areg + ((aidx == 4'd15) ? 32'd4 : 32'd0);
      a   = int'(a32[7:0]);
      case (typ)
        2'd0: begin n = (a > 33) ? 33 : a;
          for (int i = 0; i < n; i++) begin c = v[31]; v = v << 1; end end
        2'd1: begin n = (a > 33) ? 33 : a;
          for (int i = 0; i < n; i++) begin c = v[0]; v = v >> 1; end end
        2'd2: begin n = (a > 32) ? 32 : a;
          for (int i = 0; i < n; i++) begin c = v[0]; v = {v[31], v[31:1]}; end end
        default: begin
          n = (a == 0) ? 0 : (((a % 32) == 0) ? 32 : (a % 32));
          for (int i = 0; i < n; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
        end
      endcase
      return {c, v};
    end
    v = vreg;
    case (typ)
      2'd0: for (int i = 0; i < shamt; i++) begin c = v[31]; v = v << 1; end
      2'd1: begin n = (shamt == 0) ? 32 : int'(shamt);
        for (int i = 0; i < n; i++) begin c = v[0]; v = v >> 1; end end
      2'd2: begin n = (shamt == 0) ? 32 : int'(shamt);
        for (int i = 0; i < n; i++) begin c = v[0]; v = {v[31], v[31:1]}; end end
      default: begin
        if (shamt == 0) begin c = v[0]; v = {cin, v[31:1]}; end
        else for (int i = 0; i < shamt; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
      end
    endcase
    return {c, v};
  endfunction

  task automatic drive(
    input logic [1:0] form, input logic [1:0] typ, input logic [7:0] imm,
    input logic [3:0] rot, input logic [4:0] shamt,
    input logic [31:0] vreg, input logic [3:0] vidx,
    input logic [31:0] areg, input logic [3:0] aidx, input logic cin,
    input string tag);
    logic [32:0] m;
    exp_t e;
    @(negedge clk);
    form_i = form; shtype_i = typ; imm_i = imm; rot_i = rot; shamt_i = shamt;
    val_reg_i = vreg; val_idx_i = vidx; amt_reg_i = areg; amt_idx_i = aidx;
    carry_i = cin;
    m = model(form, typ, imm, rot, shamt, vreg, vidx, areg, aidx, cin);
    e.op = m[31:0]; e.c = m[32]; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: result is due on the rising edge after the drive
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (operand_o !== e.op || carry_o !== e.c) begin
        n_fail++;
        $display("FAIL %s: actual op=%h c=%b expected op=%h c=%b",
                 e.tag, operand_o, carry_o, e.op, e.c);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    form_i = 2'd1; shtype_i = 2'd1; imm_i = 8'hFF; rot_i = 4'd3; shamt_i = 5'd3;
    val_reg_i = 32'hDEADBEEF; val_idx_i = 4'd1; amt_reg_i = 32'd5; amt_idx_i = 4'd2;
    carry_i = 1'b1;
    repeat (3) @(negedge clk);
    n_vec++;
    if (operand_o !== 32'd0 || carry_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 reset: actual op=%h c=%b expected op=00000000 c=0",
               operand_o, carry_o);
    end
    rst_n = 1'b1;

    // R1 constant form
    drive(2'd0, 2'd0, 8'hA5, 4'd0, 5'd0, 32'h0, 4'd0, 32'h0, 4'd0, 1'b1, "R1 rot0");
    drive(2'd0, 2'd0, 8'hF0, 4'd4, 5'd0, 32'h0, 4'd0, 32'h0, 4'd0, 1'b0, "R1 rot8");
    drive(2'd0, 2'd3, 8'h01, 4'd1, 5'd0, 32'h0, 4'd0, 32'h0, 4'd0, 1'b1, "R1 rot2");
    drive(2'd0, 2'd1, 8'h81, 4'd15, 5'd0, 32'h0, 4'd0, 32'h0, 4'd0, 1'b0, "R1 rot30");
    // R2 nonzero constant amounts
    drive(2'd1, 2'd0, 8'h0, 4'd0, 5'd4,  32'h8000000F, 4'd2, 32'h0, 4'd0, 1'b1, "R2 lsl4");
    drive(2'd1, 2'd0, 8'h0, 4'd0, 5'd1,  32'h80000000, 4'd2, 32'h0, 4'd0, 1'b0, "R2 lsl1");
    drive(2'd1, 2'd1, 8'h0, 4'd0, 5'd31, 32'hC0000001, 4'd2, 32'h0, 4'd0, 1'b0, "R2 lsr31");
    drive(2'd1, 2'd2, 8'h0, 4'd0, 5'd8,  32'h80F00000, 4'd2, 32'h0, 4'd0, 1'b0, "R2 asr8");
    drive(2'd1, 2'd3, 8'h0, 4'd0, 5'd4,  32'h1234567F, 4'd2, 32'h0, 4'd0, 1'b0, "R2 ror4");
    // R3
    drive(2'd1, 2'd0, 8'h0, 4'd0, 5'd0, 32'hCAFEF00D, 4'd3, 32'h0, 4'd0, 1'b1, "R3 lsl0");
    // R4
    drive(2'd1, 2'd1, 8'h0, 4'd0, 5'd0, 32'h80000001, 4'd3, 32'h0, 4'd0, 1'b0, "R4 lsr0");
    drive(2'd1, 2'd2, 8'h0, 4'd0, 5'd0, 32'h80000000, 4'd3, 32'h0, 4'd0, 1'b0, "R4 asr0 neg");
    drive(2'd1, 2'd2, 8'h0, 4'd0, 5'd0, 32'h7FFFFFFF, 4'd3, 32'h0, 4'd0, 1'b1, "R4 asr0 pos");
    // R5
    drive(2'd1, 2'd3, 8'h0, 4'd0, 5'd0, 32'h00000003, 4'd3, 32'h0, 4'd0, 1'b1, "R5 rrx c1");
    drive(2'd1, 2'd3, 8'h0, 4'd0, 5'd0, 32'hFFFFFFFE, 4'd3, 32'h0, 4'd0, 1'b0, "R5 rrx c0");
    // R6 clamps and low 8 bits
    drive(2'd2, 2'd0, 8'h0, 4'd0, 5'd0, 32'h00000001, 4'd4, 32'd32,  4'd5, 1'b0, "R6 lsl32");
    drive(2'd2, 2'd0, 8'h0, 4'd0, 5'd0, 32'hFFFFFFFF, 4'd4, 32'd33,  4'd5, 1'b1, "R6 lsl33");
    drive(2'd2, 2'd1, 8'h0, 4'd0, 5'd0, 32'h80000000, 4'd4, 32'd32,  4'd5, 1'b0, "R6 lsr32");
    drive(2'd2, 2'd1, 8'h0, 4'd0, 5'd0, 32'hFFFFFFFF, 4'd4, 32'd200, 4'd5, 1'b1, "R6 lsr200");
    drive(2'd2, 2'd2, 8'h0, 4'd0, 5'd0, 32'h80000000, 4'd4, 32'd100, 4'd5, 1'b0, "R6 asr100");
    drive(2'd2, 2'd1, 8'h0, 4'd0, 5'd0, 32'hF0000000, 4'd4, 32'h00001F04, 4'd5, 1'b0, "R6 low8 only");
    // R7 zero amount
    drive(2'd2, 2'd0, 8'h0, 4'd0, 5'd0, 32'h12345678, 4'd4, 32'h00000100, 4'd5, 1'b1, "R7 lsl0");
    drive(2'd2, 2'd2, 8'h0, 4'd0, 5'd0, 32'h87654321, 4'd4, 32'h0, 4'd5, 1'b0, "R7 asr0");
    drive(2'd2, 2'd3, 8'h0, 4'd0, 5'd0, 32'h87654321, 4'd4, 32'h0, 4'd5, 1'b1, "R7 ror0");
    // R8
    drive(2'd2, 2'd3, 8'h0, 4'd0, 5'd0, 32'h80000001, 4'd4, 32'd32, 4'd5, 1'b0, "R8 ror32");
    drive(2'd2, 2'd3, 8'h0, 4'd0, 5'd0, 32'h7FFFFFFE, 4'd4, 32'd64, 4'd5, 1'b1, "R8 ror64");
    drive(2'd2, 2'd3, 8'h0, 4'd0, 5'd0, 32'h0000F00F, 4'd4, 32'd36, 4'd5, 1'b0, "R8 ror36");
    // R9 index 15 adjustment
    drive(2'd2, 2'd0, 8'h0, 4'd0, 5'd0, 32'h00000100, 4'd15, 32'd1,  4'd5,  1'b0, "R9 value pc");
    drive(2'd2, 2'd1, 8'h0, 4'd0, 5'd0, 32'hFFFFFFFF, 4'd3,  32'd28, 4'd15, 1'b0, "R9 amount pc");
    drive(2'd2, 2'd0, 8'h0, 4'd0, 5'd0, 32'h00000005, 4'd3,  32'hFFFFFFFC, 4'd15, 1'b1, "R9 amount wrap");
    drive(2'd1, 2'd0, 8'h0, 4'd0, 5'd1, 32'h00000100, 4'd15, 32'd0,  4'd15, 1'b0, "R9 no adj form1");
    // R10
    drive(2'd3, 2'd3, 8'h0, 4'd0, 5'd0, 32'h00000001, 4'd15, 32'd0, 4'd0, 1'b1, "R10 alt rrx");
    drive(2'd3, 2'd1, 8'h0, 4'd0, 5'd0, 32'hFFFFFFFF, 4'd2,  32'd0, 4'd0, 1'b0, "R10 alt lsr0");
    drive(2'd3, 2'd2, 8'h0, 4'd0, 5'd7, 32'h80000080, 4'd2,  32'd0, 4'd0, 1'b0, "R10 alt asr7");
    // R11 back-to-back latency: alternating results
    drive(2'd0, 2'd0, 8'hFF, 4'd0, 5'd0, 32'h0, 4'd0, 32'h0, 4'd0, 1'b0, "R11 seq a");
    drive(2'd0, 2'd0, 8'h00, 4'd0, 5'd0, 32'h0, 4'd0, 32'h0, 4'd0, 1'b1, "R11 seq b");
    drive(2'd0, 2'd0, 8'hFF, 4'd0, 5'd0, 32'h0, 4'd0, 32'h0, 4'd0, 1'b0, "R11 seq c");

    // random mix, labelled R2 (main function across all forms)
    for (int k = 0; k < 600; k++) begin
      logic [31:0] ar;
      ar = $urandom;
      if ((k % 3) != 0) ar = $urandom_range(0, 70);
      drive(2'($urandom), 2'($urandom), 8'($urandom), 4'($urandom), 5'($urandom),
            $urandom, 4'($urandom), ar, 4'($urandom), 1'($urandom), "R2 random");
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule